// File: doc/BRIEF.md
# Read-Path Blanking and Read-Gate Controller

This block sits between a double-frequency read channel and the character assembler. Everything it does is counted in half-cell ticks of 400 ns, which arrive as a one-cycle `tick_en` strobe. When a recorded area starts, the raw pulses are distorted while the write current that recorded them was still rising. For that reason a blanking output (`blk_rd`) holds back pulses from the clock-recovery sync input for a fixed window. After the last check character the same output is raised again and stays high until the next area begins.

Once blanking ends, the preamble has had time to pull the oscillator into lock. The separated data pulses of the all-ones gain character then retrigger a short data-gap timer. When the one-character data gap lets that timer expire, the read gate opens and separated data may flow to character assembly.

While the gate is open, the block looks for the sync clock pulse. This pulse is expected in the clock half-cell that follows data half-cell 7 of every character. When the pulse is absent, the block emits a one-cycle `sync_miss` pulse, which lets downstream logic recognise the start of the check region.

Top module: `rdg_read_ctrl`

## Requirements
- R1: An `area_start` seen on a tick raises `blk_rd` at that tick. `blk_rd` then falls at the tick WIN_TICKS (default 40) ticks later, unless a newer `area_start` restarts the window.
- R2: A `check_end` seen on a tick raises `blk_rd`. It then stays high, with no time limit, until a later `area_start` starts a new window.
- R3: While `blk_rd` is low and the gate is closed, each `data_pulse` restarts a timer of GAP_TICKS (default 8) ticks. `rd_gate` rises at the tick exactly GAP_TICKS ticks after the last data pulse, provided no other data pulse arrives in between.
- R4: `data_pulse` seen while `blk_rd` is high has no effect, and the timer is never armed without a data pulse after blanking ends. In both cases `rd_gate` stays low.
- R5: While `rd_gate` is high, ticks are numbered from 0 (the first gate-high tick) modulo HALF_CELLS (default 16). Phase 0 is the sync clock half-cell. A tick at phase 0 with `clk_pulse` low gives `sync_miss` high for exactly one clock. `sync_miss` never fires while the gate is low.
- R6: A `check_end` seen on a tick clears `rd_gate` and disarms the timer. When it arrives on the same tick as `area_start`, `check_end` wins and blanking is held.
- R7: A synchronous active-high reset gives `blk_rd`=1 (held), `rd_gate`=0, `sync_miss`=0 and a disarmed timer.
- R8: All inputs are ignored on clock cycles where `tick_en` is low, and `sync_miss` is low on such cycles.
- R9: An `area_start` disarms a pending gap timer but leaves an already open `rd_gate` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle strobe per 400 ns half-cell |
| area_start | input | 1 | Start of an address or record area |
| data_pulse | input | 1 | Separated data-bit pulse |
| clk_pulse | input | 1 | Separated clock-bit pulse |
| check_end | input | 1 | Last check-character bit has passed |
| blk_rd | output | 1 | Block sync pulses from the clock-recovery input |
| rd_gate | output | 1 | Pass separated data to character assembly |
| sync_miss | output | 1 | One-cycle pulse: sync clock absent at phase 0 |

## Verification
The hardest situations to reach from the ports are the ones where the timer would expire at the very tick that a competing event arrives. Three cases stand out:
- data pulses spaced exactly one tick short of the timeout;
- an `area_start` that lands while the timer is armed;
- a simultaneous `area_start` and `check_end`.

The stimulus reaches each of these by counting ticks from the fall of `blk_rd`. A second pass then repeats the gate-opening sequence with three junk-input, non-tick cycles between ticks, which shows that only ticks are sampled.

// File: rtl/rdg_pkg.sv
package rdg_pkg;
  typedef enum logic [1:0] {
    BW_HELD  = 2'd0,
    BW_COUNT = 2'd1,
    BW_OPEN  = 2'd2
  } blank_mode_t;
endpackage

// File: rtl/rdg_blank_win.sv
module rdg_blank_win #(
  parameter int WIN_TICKS = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic area_start,
  input  logic check_end,
  output logic blk_rd
);
  import rdg_pkg::*;
  localparam int WIN_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_TICKS - 1);

  blank_mode_t      mode;
  logic [WIN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= BW_HELD;
      cnt    <= '0;
      blk_rd <= 1'b1;
    end else if (tick_en) begin
      if (check_end) begin
        mode   <= BW_HELD;
        blk_rd <= 1'b1;
      end else if (area_start) begin
        mode   <= BW_COUNT;
        cnt    <= WIN_LOAD;
        blk_rd <= 1'b1;
      end else if (mode == BW_COUNT) begin
        if (cnt == '0) begin
          mode   <= BW_OPEN;
          blk_rd <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rdg_gap_timer.sv
module rdg_gap_timer #(
  parameter int GAP_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic blk_rd,
  input  logic area_start,
  input  logic check_end,
  input  logic data_pulse,
  output logic rd_gate
);
  localparam int GAP_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_TICKS - 1);

  logic             armed;
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cnt     <= '0;
      rd_gate <= 1'b0;
    end else if (tick_en) begin
      if (check_end) begin
        armed   <= 1'b0;
        rd_gate <= 1'b0;
      end else if (area_start) begin
        armed <= 1'b0;
      end else if (!rd_gate && !blk_rd) begin
        if (data_pulse) begin
          armed <= 1'b1;
          cnt   <= GAP_LOAD;
        end else if (armed) begin
          if (cnt == '0) begin
            armed   <= 1'b0;
            rd_gate <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rdg_sync_watch.sv
module rdg_sync_watch #(
  parameter int HALF_CELLS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic rd_gate,
  input  logic clk_pulse,
  output logic sync_miss
);
  localparam int PH_W = (HALF_CELLS > 1) ? $clog2(HALF_CELLS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CELLS - 1);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      sync_miss <= 1'b0;
    end else begin
      sync_miss <= 1'b0;
      if (tick_en) begin
        if (rd_gate) begin
          sync_miss <= (ph == '0) && !clk_pulse;
          ph        <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        end else begin
          ph <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rdg_read_ctrl.sv
module rdg_read_ctrl #(
  parameter int WIN_TICKS  = 40,
  parameter int GAP_TICKS  = 8,
  parameter int HALF_CELLS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic area_start,
  input  logic data_pulse,
  input  logic clk_pulse,
  input  logic check_end,
  output logic blk_rd,
  output logic rd_gate,
  output logic sync_miss
);
  rdg_blank_win #(.WIN_TICKS(WIN_TICKS)) u_blank (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .area_start(area_start), .check_end(check_end), .blk_rd(blk_rd)
  );

  rdg_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
    .clk(clk), .rst(rst), .tick_en(tick_en), .blk_rd(blk_rd),
    .area_start(area_start), .check_end(check_end),
    .data_pulse(data_pulse), .rd_gate(rd_gate)
  );

  rdg_sync_watch #(.HALF_CELLS(HALF_CELLS)) u_sync (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rd_gate(rd_gate),
    .clk_pulse(clk_pulse), .sync_miss(sync_miss)
  );
endmodule

// File: rtl/rdg_read_ctrl_chk.sv
module rdg_read_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic tick_en,
  input logic area_start,
  input logic data_pulse,
  input logic clk_pulse,
  input logic check_end,
  input logic blk_rd,
  input logic rd_gate,
  input logic sync_miss
);
  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> blk_rd && !rd_gate && !sync_miss);

  assert_blk_after_area_R1: assert property (@(posedge clk) disable iff (rst)
    tick_en && area_start && !check_end |=> blk_rd);

  assert_blk_fall_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(blk_rd) |-> $past(tick_en && !area_start && !check_end));

  assert_check_end_R2: assert property (@(posedge clk) disable iff (rst)
    tick_en && check_end |=> blk_rd && !rd_gate);

  assert_gate_rise_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_gate) |-> $past(tick_en && !data_pulse));

  assert_gate_rise_open_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_gate) |-> !blk_rd && $past(!blk_rd));

  assert_miss_source_R5: assert property (@(posedge clk) disable iff (rst)
    sync_miss |-> $past(rd_gate && tick_en && !clk_pulse));

  assert_miss_single_R5: assert property (@(posedge clk) disable iff (rst)
    sync_miss |=> !sync_miss);

  assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(blk_rd) && $stable(rd_gate) && !sync_miss);
endmodule

bind rdg_read_ctrl rdg_read_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .area_start(area_start),
  .data_pulse(data_pulse), .clk_pulse(clk_pulse), .check_end(check_end),
  .blk_rd(blk_rd), .rd_gate(rd_gate), .sync_miss(sync_miss)
);

// File: tb/tb_rdg_read_ctrl.sv
`timescale 1ns/1ps
module tb_rdg_read_ctrl;
  localparam int WIN  = 40;
  localparam int GAP  = 8;
  localparam int HC   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tk = 1'b0, a = 1'b0, d = 1'b0, c = 1'b0, e = 1'b0;
  logic blk_rd, rd_gate, sync_miss;

  int n_chk = 0;
  int n_fail = 0;
  int sparse = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rdg_read_ctrl #(.WIN_TICKS(WIN), .GAP_TICKS(GAP), .HALF_CELLS(HC)) dut (
    .clk(clk), .rst(rst), .tick_en(tk), .area_start(a), .data_pulse(d),
    .clk_pulse(c), .check_end(e), .blk_rd(blk_rd), .rd_gate(rd_gate),
    .sync_miss(sync_miss)
  );

  // Behavioural reference: tick indices and elapsed-tick arithmetic.
  int  m_mode, m_since, m_last, m_gt, m_tc;
  bit  m_blk, m_gate, m_miss, m_armed;

  always @(posedge clk) begin
    bit ob, og;
    started <= 1;
    cycles++;
    if (rst) begin
      m_mode = 0; m_since = 0; m_last = 0; m_gt = 0; m_tc = 0;
      m_blk = 1; m_gate = 0; m_miss = 0; m_armed = 0;
    end else begin
      m_miss = 0;
      if (tk) begin
        ob = m_blk; og = m_gate;
        if (og) begin
          if ((m_gt % HC) == 0 && !c) m_miss = 1;
          m_gt++;
        end else m_gt = 0;
        if (e) begin m_gate = 0; m_armed = 0; end
        else if (a) m_armed = 0;
        else if (!og && !ob) begin
          if (d) begin m_armed = 1; m_last = m_tc; end
          else if (m_armed && (m_tc - m_last) == GAP) begin
            m_gate = 1; m_armed = 0;
          end
        end
        if (e) begin m_mode = 0; m_blk = 1; end
        else if (a) begin m_mode = 1; m_since = 0; m_blk = 1; end
        else if (m_mode == 1) begin
          m_since++;
          if (m_since == WIN) begin m_blk = 0; m_mode = 2; end
        end
        m_tc++;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1/R2 blk_rd", blk_rd, m_blk);
      chk("R3 rd_gate", rd_gate, m_gate);
      chk("R5 sync_miss", sync_miss, m_miss);
    end
  end

  // One tick; in sparse mode preceded by junk non-tick cycles (R8).
  task automatic step(input logic sa, input logic sd, input logic sc, input logic se);
    for (int i = 0; i < sparse; i++) begin
      tk = 0; a = 1; d = 1; c = 0; e = 1;
      @(negedge clk);
    end
    tk = 1; a = sa; d = sd; c = sc; e = se;
    @(negedge clk);
    tk = 0; a = 0; d = 0; c = 0; e = 0;
  endtask

  task automatic idle(input int n, input logic sd);
    for (int i = 0; i < n; i++) step(0, sd, 1, 0);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R7 reset blk", blk_rd, 1'b1);
    chk("R7 reset gate", rd_gate, 1'b0);
    chk("R7 reset miss", sync_miss, 1'b0);

    // Data while held blanking: ignored
    idle(5, 1);
    chk("R4 held data ignored", rd_gate, 1'b0);

    // Scenario 1: full area
    step(1, 0, 0, 0);
    chk("R1 blk at area", blk_rd, 1'b1);
    idle(WIN - 1, 1);
    chk("R1 blk before window end", blk_rd, 1'b1);
    step(0, 1, 1, 0);
    chk("R1 blk drops", blk_rd, 1'b0);
    chk("R4 blanked data ignored", rd_gate, 1'b0);
    idle(20, 0);
    chk("R4 no arm without data", rd_gate, 1'b0);
    for (int i = 0; i < 8; i++) step(0, i[0], 1, 0);
    idle(GAP - 1, 0);
    chk("R3 gate not yet", rd_gate, 1'b0);
    idle(1, 0);
    chk("R3 gate opens", rd_gate, 1'b1);
    for (int k = 0; k < 4; k++)
      for (int h = 0; h < HC; h++) begin
        step(0, h[0], (h % 2 == 0) && !(k == 2 && h == 0), 0);
        if (h == 0 && k == 1) chk("R5 sync present no miss", sync_miss, 1'b0);
        if (h == 0 && k == 2) chk("R5 sync missing", sync_miss, 1'b1);
        if (h == 1 && k == 2) chk("R5 miss single", sync_miss, 1'b0);
      end
    step(0, 0, 0, 1);
    chk("R6 gate cleared", rd_gate, 1'b0);
    chk("R2 blk raised", blk_rd, 1'b1);
    idle(60, 1);
    chk("R2 blk held", blk_rd, 1'b1);
    chk("R5 no miss gate low", sync_miss, 1'b0);

    // Scenario 2: retrigger one tick short of timeout
    step(1, 0, 0, 0);
    idle(WIN, 0);
    step(0, 1, 1, 0); idle(GAP - 1, 0);
    step(0, 1, 1, 0); idle(GAP - 1, 0);
    step(0, 1, 1, 0);
    chk("R3 retrigger holds gate", rd_gate, 1'b0);
    idle(GAP, 0);
    chk("R3 gate after retrigger", rd_gate, 1'b1);
    step(1, 0, 1, 0);
    chk("R9 area keeps open gate", rd_gate, 1'b1);
    idle(WIN + 5, 0);
    step(0, 0, 1, 1);

    // Scenario 3: area_start disarms pending timer
    step(1, 0, 0, 0);
    idle(WIN, 0);
    step(0, 1, 1, 0);
    idle(3, 0);
    step(1, 0, 0, 0);
    idle(WIN + 30, 0);
    chk("R9 disarmed gate low", rd_gate, 1'b0);

    // Scenario 4: check_end beats area_start
    step(1, 0, 0, 1);
    idle(WIN + 20, 0);
    chk("R6 check_end priority blk held", blk_rd, 1'b1);

    // Scenario 5: sparse ticks with junk between
    sparse = 3;
    step(1, 0, 0, 0);
    idle(WIN, 0);
    chk("R8 blk dropped on ticks only", blk_rd, 1'b0);
    step(0, 1, 1, 0);
    idle(GAP, 0);
    chk("R8 gate opens with junk between ticks", rd_gate, 1'b1);
    idle(2 * HC, 0);
    step(0, 0, 1, 1);
    sparse = 0;
    idle(3, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule